// File: doc/BRIEF.md
# Two-Phase Mixed-Mode Test Pattern Generator

This block feeds stimulus to a combinational circuit under test during self-test. A run begins with a start strobe. For a fixed number of cycles the generator drives the raw state of a maximal-length linear feedback shift register onto its vector output. These vectors catch the faults that are easy to detect. The register then keeps stepping, and for a second fixed number of cycles each output column is rebuilt so that the vectors become a precomputed deterministic set.

The rebuild is set per column at elaboration time. A column can be tied to the register bit in the same position in both phases, with no multiplexer. It can be switched to a different register bit, or it can be switched to one bit of an external decoder bus. All switched columns share one select. That select comes from the internal pattern counter or, if a parameter says so, from an external phase pin. One cycle after the last deterministic vector, a done pulse marks the end of the run. The generator then holds still until the next start.

Top module: `mmb_pattern_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, the register holds the seed, `vec_o` equals the seed, and `phase_o` and `done_o` are low.
- R2: In the cycle after a start strobe, `vec_o` shows vector 0, which is the seed. Vector k for k below RAND_LEN is the register state after k steps, passed through unchanged. The step shifts the state left by one, and the new bit 0 is the XOR of the state bits selected by TAPS.
- R3: The register steps once per cycle straight across the phase boundary. Deterministic vector k is therefore built from the state after k steps.
- R4: A column coded 0 (self) equals the register bit at its own index in every phase.
- R5: In the deterministic phase, a column coded 1 (remap) equals the register bit given by its source index. In the pseudo-random phase it equals its own bit.
- R6: In the deterministic phase, a column coded 2 (decode) equals the same bit of `dec_i`. In the pseudo-random phase `dec_i` has no effect on `vec_o`.
- R7: With counter select, `phase_o` is low for vectors 0 to RAND_LEN-1 and high from vector RAND_LEN to the last vector.
- R8: `done_o` is high for exactly one cycle, the cycle after vector RAND_LEN+DET_LEN-1. After that the register, the counter and `phase_o` stay unchanged until the next start.
- R9: A start strobe in any cycle, including during a run or in the cycle of the last vector, reloads the seed and zeroes the counter. A start in the last-vector cycle suppresses that `done_o` pulse.
- R10: With EXT_SEL set, the shared select and `phase_o` follow `ext_phase_i` in the same cycle, whatever the counter value.
- R11: The register state is never all zeros.

Column codes sit in COL_KIND, two bits per column, with column i at bits [2i+1:2i]. Source indices sit in COL_SRC, eight bits per column, with column i at bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start or restart strobe for a test run |
| ext_phase_i | input | 1 | External phase select, used only when EXT_SEL = 1 |
| dec_i | input | W | Decoder result for decode-coded columns |
| vec_o | output | W | Test vector to the circuit under test |
| phase_o | output | 1 | Shared select: 1 = deterministic phase |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Two events can fall in the same cycle: the end of the run and a new start. The bench issues a start exactly in the cycle that shows the last deterministic vector. It then expects no done pulse, vector 0 (the seed) on the next cycle, and a full fresh run after that. A second start is also issued in the middle of the pseudo-random phase. `dec_i` and `ext_phase_i` carry random values on every cycle. This checks that decode columns ignore the decoder bus in the first phase, and that the externally selected instance follows its pin on every cycle.

// File: rtl/mmb_pkg.sv
package mmb_pkg;
  // Per-column mapping codes (2 bits each in COL_KIND)
  typedef enum logic [1:0] {
    MAP_SELF = 2'd0,
    MAP_COL  = 2'd1,
    MAP_DEC  = 2'd2
  } map_e;

  localparam int SRC_BITS = 8;
endpackage

// File: rtl/mmb_lfsr.sv
module mmb_lfsr #(
  parameter int           W    = 5,
  parameter logic [W-1:0] TAPS = 5'b10100,
  parameter logic [W-1:0] SEED = 5'b00001
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  // one shift step: left shift, feedback from tapped bits into bit 0
  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  logic [W-1:0] state_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || load_i) state_q <= SEED;
    else if (adv_i)      state_q <= step(state_q);
  end

  assign state_o = state_q;
endmodule

// File: rtl/mmb_phase_ctrl.sv
module mmb_phase_ctrl #(
  parameter int RAND_LEN = 12,
  parameter int DET_LEN  = 8,
  localparam int TOTAL   = RAND_LEN + DET_LEN,
  localparam int CW      = $clog2(TOTAL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          start_i,
  output logic [CW-1:0] cnt_o,
  output logic          run_o,
  output logic          last_o,
  output logic          cnt_phase_o,
  output logic          done_o
);
  localparam logic [CW-1:0] RAND_C = CW'(RAND_LEN);
  localparam logic [CW-1:0] LAST_C = CW'(TOTAL - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          done_q;

  assign last_o      = run_q && (cnt_q == LAST_C);
  assign cnt_phase_o = (cnt_q >= RAND_C);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (last_o) begin
      run_q  <= 1'b0;
      done_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (run_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign done_o = done_q;
endmodule

// File: rtl/mmb_col_map.sv
module mmb_col_map
  import mmb_pkg::*;
#(
  parameter int               W        = 5,
  parameter logic [2*W-1:0]   COL_KIND = '0,
  parameter logic [8*W-1:0]   COL_SRC  = '0
) (
  input  logic [W-1:0] lfsr_i,
  input  logic [W-1:0] dec_i,
  input  logic         sel_i,
  output logic [W-1:0] vec_o
);
  logic unused_dec;
  assign unused_dec = ^dec_i;

  for (genvar i = 0; i < W; i++) begin : g_col
    localparam logic [1:0] KIND = COL_KIND[2*i +: 2];
    localparam int         SRC  = int'(COL_SRC[SRC_BITS*i +: SRC_BITS]);
    if (KIND == MAP_COL) begin : g_remap
      assign vec_o[i] = sel_i ? lfsr_i[SRC] : lfsr_i[i];
    end else if (KIND == MAP_DEC) begin : g_dec
      assign vec_o[i] = sel_i ? dec_i[i] : lfsr_i[i];
    end else begin : g_direct
      assign vec_o[i] = lfsr_i[i];
    end
  end
endmodule

// File: rtl/mmb_pattern_gen.sv
module mmb_pattern_gen #(
  parameter int             W        = 5,
  parameter logic [W-1:0]   TAPS     = 5'b10100,
  parameter logic [W-1:0]   SEED     = 5'b00001,
  parameter int             RAND_LEN = 12,
  parameter int             DET_LEN  = 8,
  parameter bit             EXT_SEL  = 1'b0,
  parameter logic [2*W-1:0] COL_KIND = 10'b01_00_10_01_00,
  parameter logic [8*W-1:0] COL_SRC  = {8'd0, 8'd0, 8'd0, 8'd3, 8'd0}
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         start_i,
  input  logic         ext_phase_i,
  input  logic [W-1:0] dec_i,
  output logic [W-1:0] vec_o,
  output logic         phase_o,
  output logic         done_o
);
  localparam int CW = $clog2(RAND_LEN + DET_LEN + 1);

  // named internal events for the checker
  logic [W-1:0]  lfsr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          last_evt;
  logic          cnt_phase;
  logic          adv;
  logic          sel;

  assign adv = run_q && !last_evt;

  mmb_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (start_i),
    .adv_i  (adv),
    .state_o(lfsr_q)
  );

  mmb_phase_ctrl #(.RAND_LEN(RAND_LEN), .DET_LEN(DET_LEN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (start_i),
    .cnt_o      (cnt_q),
    .run_o      (run_q),
    .last_o     (last_evt),
    .cnt_phase_o(cnt_phase),
    .done_o     (done_o)
  );

  if (EXT_SEL) begin : g_ext_sel
    logic unused_cnt_phase;
    assign unused_cnt_phase = cnt_phase;
    assign sel = ext_phase_i;
  end else begin : g_cnt_sel
    logic unused_ext;
    assign unused_ext = ext_phase_i;
    assign sel = cnt_phase;
  end

  mmb_col_map #(.W(W), .COL_KIND(COL_KIND), .COL_SRC(COL_SRC)) u_map (
    .lfsr_i(lfsr_q),
    .dec_i (dec_i),
    .sel_i (sel),
    .vec_o (vec_o)
  );

  assign phase_o = sel;
endmodule

// File: rtl/mmb_checker.sv
module mmb_checker
  import mmb_pkg::*;
#(
  parameter int             W        = 5,
  parameter logic [W-1:0]   SEED     = 5'b00001,
  parameter int             RAND_LEN = 12,
  parameter int             CW       = 5,
  parameter bit             EXT_SEL  = 1'b0,
  parameter logic [2*W-1:0] COL_KIND = '0
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          start_i,
  input logic [W-1:0]  lfsr_q,
  input logic [CW-1:0] cnt_q,
  input logic          run_q,
  input logic          last_evt,
  input logic [W-1:0]  vec_o,
  input logic          phase_o,
  input logic          done_o
);
  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  // R8: idle generator holds its register
  a_r8_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_q && !start_i) |=> $stable(lfsr_q) && $stable(cnt_q));

  // R9: start reloads seed and clears the counter
  a_r9_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    start_i |=> (lfsr_q == SEED) && (cnt_q == '0) && run_q && !done_o);

  // R3: register keeps stepping while running
  a_r3_advance: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && !start_i && !last_evt) |=> (lfsr_q != $past(lfsr_q)));

  // R11: never the lock-up state
  a_r11_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
    lfsr_q != '0);

  // R7: deterministic phase starts at vector RAND_LEN under counter select
  a_r7_phase_start: assert property (@(posedge clk_i) disable iff (rst_i)
    (!EXT_SEL && run_q && cnt_q == CW'(RAND_LEN)) |-> phase_o);

  // R4: direct columns follow their own register bit
  for (genvar i = 0; i < W; i++) begin : g_direct_chk
    if (COL_KIND[2*i +: 2] == MAP_SELF) begin : g_on
      a_r4_direct: assert property (@(posedge clk_i) disable iff (rst_i)
        vec_o[i] == lfsr_q[i]);
    end
  end
endmodule

bind mmb_pattern_gen mmb_checker #(
  .W(W), .SEED(SEED), .RAND_LEN(RAND_LEN), .CW(CW),
  .EXT_SEL(EXT_SEL), .COL_KIND(COL_KIND)
) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .start_i (start_i),
  .lfsr_q  (lfsr_q),
  .cnt_q   (cnt_q),
  .run_q   (run_q),
  .last_evt(last_evt),
  .vec_o   (vec_o),
  .phase_o (phase_o),
  .done_o  (done_o)
);

// File: tb/sim_mmb_pattern_gen.sv
module sim_mmb_pattern_gen;
  localparam int             W        = 5;
  localparam logic [W-1:0]   TAPS     = 5'b10100;
  localparam logic [W-1:0]   SEED     = 5'b00001;
  localparam int             RAND_LEN = 12;
  localparam int             DET_LEN  = 8;
  localparam int             TOTAL    = RAND_LEN + DET_LEN;
  localparam logic [2*W-1:0] KINDS    = 10'b01_00_10_01_00;
  localparam logic [8*W-1:0] SRCS     = {8'd0, 8'd0, 8'd0, 8'd3, 8'd0};

  // bench's own view of the column map: 0 self, 1 remap, 2 decode
  int kind_tb [W] = '{0, 1, 2, 0, 1};
  int src_tb  [W] = '{0, 3, 0, 0, 0};

  logic clk = 1'b0;
  logic rst, start, ext_ph;
  logic [W-1:0] dec;
  logic [W-1:0] vec0, vec1;
  logic ph0, ph1, done0, done1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mmb_pattern_gen #(.W(W), .TAPS(TAPS), .SEED(SEED), .RAND_LEN(RAND_LEN),
    .DET_LEN(DET_LEN), .EXT_SEL(1'b0), .COL_KIND(KINDS), .COL_SRC(SRCS)) u0 (
    .clk_i(clk), .rst_i(rst), .start_i(start), .ext_phase_i(ext_ph),
    .dec_i(dec), .vec_o(vec0), .phase_o(ph0), .done_o(done0));

  mmb_pattern_gen #(.W(W), .TAPS(TAPS), .SEED(SEED), .RAND_LEN(RAND_LEN),
    .DET_LEN(DET_LEN), .EXT_SEL(1'b1), .COL_KIND(KINDS), .COL_SRC(SRCS)) u1 (
    .clk_i(clk), .rst_i(rst), .start_i(start), .ext_phase_i(ext_ph),
    .dec_i(dec), .vec_o(vec1), .phase_o(ph1), .done_o(done1));

  typedef struct {
    logic [W-1:0] v0;
    logic [W-1:0] v1;
    logic         p0;
    logic         p1;
    logic         d;
  } exp_t;

  exp_t sb[$];

  // reference model state
  logic [W-1:0] m_lfsr;
  int           m_cnt;
  bit           m_run;
  bit           m_done;

  function automatic logic [W-1:0] ref_step(input logic [W-1:0] s);
    logic fb = 1'b0;
    for (int j = 0; j < W; j++) if (TAPS[j]) fb = fb ^ s[j];
    return (s << 1) | {{(W-1){1'b0}}, fb};
  endfunction

  function automatic logic [W-1:0] ref_vec(input logic [W-1:0] s,
                                           input logic [W-1:0] d,
                                           input logic         sel);
    logic [W-1:0] r;
    for (int c = 0; c < W; c++) begin
      if (!sel || kind_tb[c] == 0) r[c] = s[c];
      else if (kind_tb[c] == 1)    r[c] = s[src_tb[c]];
      else                         r[c] = d[c];
    end
    return r;
  endfunction

  function automatic string col_tag(input int c, input logic sel);
    if (kind_tb[c] == 0) return "R4";
    if (!sel)            return "R2";
    if (kind_tb[c] == 1) return "R5";
    return "R6";
  endfunction

  // driver: drive inputs at the falling edge, advance model, push expectation
  task automatic tick(input bit s);
    exp_t e;
    start  = s;
    dec    = W'($urandom);
    ext_ph = 1'($urandom);
    if (s) begin
      m_lfsr = SEED; m_cnt = 0; m_run = 1'b1; m_done = 1'b0;
    end else if (m_run && m_cnt == TOTAL - 1) begin
      m_run = 1'b0; m_done = 1'b1;
    end else begin
      m_done = 1'b0;
      if (m_run) begin
        m_lfsr = ref_step(m_lfsr);
        m_cnt  = m_cnt + 1;
      end
    end
    e.p0 = (m_cnt >= RAND_LEN);
    e.p1 = ext_ph;
    e.v0 = ref_vec(m_lfsr, dec, e.p0);
    e.v1 = ref_vec(m_lfsr, dec, e.p1);
    e.d  = m_done;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare one item per cycle shortly after the rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (ph0 !== e.p0) begin
        errors++; $display("FAIL R7 phase got %0b exp %0b", ph0, e.p0);
      end
      checks++;
      if (done0 !== e.d || done1 !== e.d) begin
        errors++;
        $display("FAIL R8 done got %0b/%0b exp %0b", done0, done1, e.d);
      end
      for (int c = 0; c < W; c++) begin
        checks++;
        if (vec0[c] !== e.v0[c]) begin
          errors++;
          $display("FAIL %s col %0d vec got %b exp %b", col_tag(c, e.p0), c, vec0, e.v0);
        end
      end
      checks++;
      if (ph1 !== e.p1 || vec1 !== e.v1) begin
        errors++;
        $display("FAIL R10 ext-select got ph %0b vec %b exp ph %0b vec %b",
                 ph1, vec1, e.p1, e.v1);
      end
    end
  end

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; start = 1'b0; ext_ph = 1'b0; dec = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state visible at the ports
    checks++;
    if (vec0 !== SEED || ph0 !== 1'b0 || done0 !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset got vec %b ph %0b done %0b exp vec %b ph 0 done 0",
               vec0, ph0, done0, SEED);
    end
    m_lfsr = SEED; m_cnt = 0; m_run = 1'b0; m_done = 1'b0;

    // idle after reset: R1 state persists, decode ignored (R6)
    repeat (2) tick(1'b0);

    // R9: start, then restart in the middle of the pseudo-random phase
    tick(1'b1);
    repeat (5) tick(1'b0);
    tick(1'b1);
    // full run through both phases (R2, R3, R5, R6, R7), done and hold (R8)
    repeat (TOTAL + 3) tick(1'b0);

    // R9 collision: start in the last-vector cycle suppresses done
    tick(1'b1);
    repeat (TOTAL - 1) tick(1'b0);
    tick(1'b1);
    repeat (TOTAL + 2) tick(1'b0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule